// File: doc/BRIEF.md
# LPDDR2 Power-Up Initialization Sequencer

This block brings an LPDDR2 SDRAM from power-up to its normal operating state. It walks a fixed list of fifteen commands, inserts the mandatory minimum waits between certain steps, and flips two side controls partway through the list. The first side control selects the ZQ calibration type (reset or short). The second enables the input buffers. When the final command has been taken and the input buffers have closed again, a done flag rises and stays high until the next reset.

Commands leave the block on a valid/ready stream. A command stays on `cmd_op`/`cmd_idx` with `cmd_valid` high until the downstream command path accepts it with `cmd_ready`. Back-pressure is unbounded: the sequencer never drops or changes a presented command. All minimum waits are counted from the cycle after the accepting edge. The PHY, the contents of the mode registers and refresh timing belong to other blocks.

The waits are given in time units and converted to clock cycles using the clock frequency parameter, with each result rounded up.

Top module: `lp2_init_seq`

## Requirements
- R1: While reset is low, `cmd_valid`, `zq_short`, `ibuf_en` and `done` are 0. `cmd_valid` is first high after the first rising clock edge that follows reset release.
- R2: While `cmd_valid` is 1 and `cmd_ready` is 0, the next cycle still has `cmd_valid` at 1 with `cmd_op` and `cmd_idx` unchanged.
- R3: Commands are presented in this order, with op codes NOP=0, ACK_WRITE=1, MRW=2 and NORMAL=3: NOP, ACK_WRITE, NOP, MRW 63 (device reset), MRW 10 (calibration), MRW 1, MRW 2, MRW 3, MRW 16, NOP, MRW 5, MRW 6, MRW 8, MRW 0, NORMAL.
- R4: `cmd_idx` is 0 whenever a command other than MRW is presented.
- R5: After ACK_WRITE is accepted, `cmd_valid` stays low for exactly ceil(T_ACK_NS*CLK_MHZ/1000) cycles (20 by default).
- R6: After the second NOP is accepted, `cmd_valid` stays low for exactly T_RST_US*CLK_MHZ cycles (40000 by default).
- R7: After MRW 63 is accepted, `cmd_valid` stays low for exactly ceil(T_INIT5_NS*CLK_MHZ/1000) cycles (200 by default).
- R8: After any other command is accepted except the last, the next command is valid in the very next cycle.
- R9: `zq_short` is 0 (reset type) up to and including the cycle in which MRW 10 is accepted. It is 1 (short type) from the next cycle until reset.
- R10: `ibuf_en` rises in the cycle after MRW 16 is accepted. It stays high through NORMAL and falls in the cycle after NORMAL is accepted.
- R11: `done` rises exactly one cycle after `ibuf_en` falls. It then stays high, and `cmd_valid` stays 0.
- R12: Reset applied at any point in the sequence clears `zq_short`, `ibuf_en` and `done`. The whole sequence then restarts from the first NOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | output | 1 | Command present on cmd_op/cmd_idx |
| cmd_ready | input | 1 | Downstream accepts the presented command |
| cmd_op | output | 2 | Command code (NOP=0, ACK_WRITE=1, MRW=2, NORMAL=3) |
| cmd_idx | output | 6 | Mode register index for MRW, zero otherwise |
| zq_short | output | 1 | ZQ calibration type: 0 reset, 1 short |
| ibuf_en | output | 1 | Input buffer enable |
| done | output | 1 | Initialization complete (sticky) |

## Verification
The accepting edge of MRW 10 and the accepting edge of MRW 16 each do two things at once. They change a side control, and they put the next command on the stream in the same cycle. The accepting edge of NORMAL likewise closes the input buffers in the cycle before done rises. The bench accepts each command, then samples the stream and both side controls at the following falling edge. It expects the new command to be valid together with the new `zq_short`/`ibuf_en` value, never the old one. It repeats this with `cmd_ready` held back for several cycles, so that a stalled command is shown to leave both side controls untouched until acceptance.

// File: rtl/lp2_init_pkg.sv
package lp2_init_pkg;

  typedef enum logic [1:0] {
    OP_NOP    = 2'd0,
    OP_WRACK  = 2'd1,
    OP_MRW    = 2'd2,
    OP_NORMAL = 2'd3
  } lp2_op_e;

  typedef enum logic [1:0] {
    GAP_NONE  = 2'd0,
    GAP_ACK   = 2'd1,
    GAP_RST   = 2'd2,
    GAP_INIT5 = 2'd3
  } lp2_gap_e;

  typedef struct packed {
    lp2_op_e    op;
    logic [5:0] idx;
    lp2_gap_e   gap_after;
    logic       zq_flip;
    logic       ibuf_open;
    logic       ibuf_close;
  } lp2_step_t;

  localparam int NUM_STEPS = 15;
  localparam int STEP_W    = $clog2(NUM_STEPS);

  function automatic lp2_step_t mk_step(lp2_op_e op, logic [5:0] idx,
                                        lp2_gap_e gap, logic [2:0] flags);
    lp2_step_t s;
    s.op         = op;
    s.idx        = (op == OP_MRW) ? idx : 6'd0;
    s.gap_after  = gap;
    s.zq_flip    = flags[2];
    s.ibuf_open  = flags[1];
    s.ibuf_close = flags[0];
    return s;
  endfunction

  // Fixed power-up program; the MRW index order is not monotonic by intent.
  function automatic lp2_step_t step_entry(logic [STEP_W-1:0] n);
    lp2_step_t s;
    case (n)
      4'd0:    s = mk_step(OP_NOP,    6'd0,  GAP_NONE,  3'b000);
      4'd1:    s = mk_step(OP_WRACK,  6'd0,  GAP_ACK,   3'b000);
      4'd2:    s = mk_step(OP_NOP,    6'd0,  GAP_RST,   3'b000);
      4'd3:    s = mk_step(OP_MRW,    6'd63, GAP_INIT5, 3'b000);
      4'd4:    s = mk_step(OP_MRW,    6'd10, GAP_NONE,  3'b100);
      4'd5:    s = mk_step(OP_MRW,    6'd1,  GAP_NONE,  3'b000);
      4'd6:    s = mk_step(OP_MRW,    6'd2,  GAP_NONE,  3'b000);
      4'd7:    s = mk_step(OP_MRW,    6'd3,  GAP_NONE,  3'b000);
      4'd8:    s = mk_step(OP_MRW,    6'd16, GAP_NONE,  3'b010);
      4'd9:    s = mk_step(OP_NOP,    6'd0,  GAP_NONE,  3'b000);
      4'd10:   s = mk_step(OP_MRW,    6'd5,  GAP_NONE,  3'b000);
      4'd11:   s = mk_step(OP_MRW,    6'd6,  GAP_NONE,  3'b000);
      4'd12:   s = mk_step(OP_MRW,    6'd8,  GAP_NONE,  3'b000);
      4'd13:   s = mk_step(OP_MRW,    6'd0,  GAP_NONE,  3'b000);
      4'd14:   s = mk_step(OP_NORMAL, 6'd0,  GAP_NONE,  3'b001);
      default: s = mk_step(OP_NOP,    6'd0,  GAP_NONE,  3'b000);
    endcase
    return s;
  endfunction

endpackage

// File: rtl/lp2_step_rom.sv
module lp2_step_rom
  import lp2_init_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  output lp2_step_t         ent,
  output logic              last
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  always_comb begin
    ent  = step_entry(step);
    last = (step == LAST_STEP);
  end

endmodule

// File: rtl/lp2_wait_timer.sv
module lp2_wait_timer
  import lp2_init_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int W_ACK   = 20,
  parameter int W_RST   = 40000,
  parameter int W_INIT5 = 200
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  lp2_gap_e sel,
  output logic     busy
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    case (sel)
      GAP_ACK:   load_val = CNT_W'(W_ACK);
      GAP_RST:   load_val = CNT_W'(W_RST);
      GAP_INIT5: load_val = CNT_W'(W_INIT5);
      default:   load_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/lp2_side_ctrl.sv
module lp2_side_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic zq_flip,
  input  logic ibuf_open,
  input  logic ibuf_close,
  output logic zq_short,
  output logic ibuf_en
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zq_short <= 1'b0;
      ibuf_en  <= 1'b0;
    end else if (accept) begin
      if (zq_flip)    zq_short <= 1'b1;
      if (ibuf_open)  ibuf_en  <= 1'b1;
      if (ibuf_close) ibuf_en  <= 1'b0;
    end
  end

endmodule

// File: rtl/lp2_init_seq.sv
module lp2_init_seq
  import lp2_init_pkg::*;
#(
  parameter int CLK_MHZ    = 200,
  parameter int T_ACK_NS   = 100,
  parameter int T_RST_US   = 200,
  parameter int T_INIT5_NS = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       cmd_valid,
  input  logic       cmd_ready,
  output logic [1:0] cmd_op,
  output logic [5:0] cmd_idx,
  output logic       zq_short,
  output logic       ibuf_en,
  output logic       done
);

  localparam int W_ACK   = (T_ACK_NS * CLK_MHZ + 999) / 1000;
  localparam int W_RST   = T_RST_US * CLK_MHZ;
  localparam int W_INIT5 = (T_INIT5_NS * CLK_MHZ + 999) / 1000;
  localparam int W_MAX01 = (W_ACK > W_RST) ? W_ACK : W_RST;
  localparam int W_MAX   = (W_MAX01 > W_INIT5) ? W_MAX01 : W_INIT5;
  localparam int CNT_W   = $clog2(W_MAX + 1);

  typedef enum logic [1:0] {S_START, S_RUN, S_CLOSE, S_DONE} seq_state_e;

  seq_state_e        state_q;
  logic [STEP_W-1:0] step_q;
  lp2_step_t         ent;
  logic              last;
  logic              busy;
  logic              accept;

  lp2_step_rom u_rom (
    .step (step_q),
    .ent  (ent),
    .last (last)
  );

  lp2_wait_timer #(
    .CNT_W   (CNT_W),
    .W_ACK   (W_ACK),
    .W_RST   (W_RST),
    .W_INIT5 (W_INIT5)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .sel   (ent.gap_after),
    .busy  (busy)
  );

  lp2_side_ctrl u_side (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .zq_flip    (ent.zq_flip),
    .ibuf_open  (ent.ibuf_open),
    .ibuf_close (ent.ibuf_close),
    .zq_short   (zq_short),
    .ibuf_en    (ibuf_en)
  );

  assign cmd_valid = (state_q == S_RUN) && !busy;
  assign accept    = cmd_valid && cmd_ready;
  assign cmd_op    = ent.op;
  assign cmd_idx   = ent.idx;
  assign done      = (state_q == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_START;
      step_q  <= '0;
    end else begin
      case (state_q)
        S_START: begin
          state_q <= S_RUN;
          step_q  <= '0;
        end
        S_RUN: begin
          if (accept) begin
            if (last) state_q <= S_CLOSE;
            else      step_q  <= step_q + 1'b1;
          end
        end
        S_CLOSE: state_q <= S_DONE;
        default: state_q <= S_DONE;
      endcase
    end
  end

endmodule

// File: rtl/lp2_init_seq_chk.sv
module lp2_init_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_op,
  input logic [5:0] cmd_idx,
  input logic       zq_short,
  input logic       ibuf_en,
  input logic       done
);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_idx));

  // R4
  idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op != 2'd2 |-> cmd_idx == 6'd0);

  // R9
  zq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zq_short |=> zq_short);

  // R10
  ibuf_needs_zq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ibuf_en |-> zq_short);

  // R11
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R11
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_valid && !ibuf_en);

  // R11
  done_after_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(ibuf_en, 2) && !$past(ibuf_en));

endmodule

bind lp2_init_seq lp2_init_seq_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .cmd_idx   (cmd_idx),
  .zq_short  (zq_short),
  .ibuf_en   (ibuf_en),
  .done      (done)
);

// File: tb/lp2_init_seq_tb_top.sv
`timescale 1ns/1ps
module lp2_init_seq_tb_top;

  localparam int CLK_MHZ = 200;
  localparam int GAP_ACK = (100 * CLK_MHZ + 999) / 1000;
  localparam int GAP_RST = 200 * CLK_MHZ;
  localparam int GAP_I5  = (1000 * CLK_MHZ + 999) / 1000;

  // {op[1:0], idx[5:0], gap-before code[1:0]}: 0 none, 1 ack, 2 reset, 3 tINIT5
  localparam logic [9:0] VEC [15] = '{
    {2'd0, 6'd0,  2'd0}, {2'd1, 6'd0,  2'd0}, {2'd0, 6'd0,  2'd1},
    {2'd2, 6'd63, 2'd2}, {2'd2, 6'd10, 2'd3}, {2'd2, 6'd1,  2'd0},
    {2'd2, 6'd2,  2'd0}, {2'd2, 6'd3,  2'd0}, {2'd2, 6'd16, 2'd0},
    {2'd0, 6'd0,  2'd0}, {2'd2, 6'd5,  2'd0}, {2'd2, 6'd6,  2'd0},
    {2'd2, 6'd8,  2'd0}, {2'd2, 6'd0,  2'd0}, {2'd3, 6'd0,  2'd0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_ready = 1'b0;
  logic       cmd_valid;
  logic [1:0] cmd_op;
  logic [5:0] cmd_idx;
  logic       zq_short, ibuf_en, done;

  int nvec = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lp2_init_seq #(.CLK_MHZ(CLK_MHZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_idx(cmd_idx), .zq_short(zq_short),
    .ibuf_en(ibuf_en), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gap_of(input logic [1:0] c, input int k);
    if (k == 0) return 1;  // R1: one sampled low cycle after release
    case (c)
      2'd1:    return GAP_ACK;
      2'd2:    return GAP_RST;
      2'd3:    return GAP_I5;
      default: return 0;
    endcase
  endfunction

  // Walks the table; stops presenting at step stop_at without accepting it.
  task automatic run_seq(input int stall, input int stop_at);
    for (int k = 0; k < 15; k++) begin
      int g = 0;
      while (!cmd_valid && g < 60000) begin
        g++;
        @(negedge clk);
      end
      chk(g == gap_of(VEC[k][1:0], k),
          (k == 0) ? "R1 first valid" : (VEC[k][1:0] == 2'd1) ? "R5 ack gap" :
          (VEC[k][1:0] == 2'd2) ? "R6 reset gap" : (VEC[k][1:0] == 2'd3) ? "R7 tINIT5 gap" :
          "R8 back-to-back", g, gap_of(VEC[k][1:0], k));
      chk(cmd_op == VEC[k][9:8], "R3 op order", int'(cmd_op), int'(VEC[k][9:8]));
      chk(cmd_idx == VEC[k][7:2], (VEC[k][9:8] == 2'd2) ? "R3 mrw index" : "R4 idx zero",
          int'(cmd_idx), int'(VEC[k][7:2]));
      chk(zq_short == (k >= 5), "R9 zq type", int'(zq_short), int'(k >= 5));
      chk(ibuf_en == (k >= 9), "R10 ibuf", int'(ibuf_en), int'(k >= 9));
      if (k == stop_at) return;
      for (int s = 0; s < stall; s++) begin
        logic [1:0] op0 = cmd_op;
        logic [5:0] ix0 = cmd_idx;
        logic       zq0 = zq_short;
        logic       ib0 = ibuf_en;
        @(negedge clk);
        chk(cmd_valid && cmd_op == op0 && cmd_idx == ix0, "R2 stall hold",
            {cmd_valid, cmd_op, cmd_idx}, {1'b1, op0, ix0});
        chk(zq_short == zq0 && ibuf_en == ib0, "R9 R10 stall side", {zq_short, ibuf_en}, {zq0, ib0});
      end
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
    end
  endtask

  task automatic check_tail();
    chk(!ibuf_en && !done && !cmd_valid, "R10 ibuf close",
        {ibuf_en, done, cmd_valid}, 3'b000);
    @(negedge clk);
    chk(done && !ibuf_en, "R11 done rise", {done, ibuf_en}, 2'b10);
    repeat (5) @(negedge clk);
    chk(done && !cmd_valid, "R11 done sticky", {done, cmd_valid}, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!cmd_valid && !zq_short && !ibuf_en && !done, "R1 reset state",
        {cmd_valid, zq_short, ibuf_en, done}, 0);
    rst_n = 1'b1;
    run_seq(0, 99);
    check_tail();

    // reset after both side controls have switched
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    run_seq(1, 10);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!cmd_valid && !zq_short && !ibuf_en && !done, "R12 mid reset",
        {cmd_valid, zq_short, ibuf_en, done}, 0);
    rst_n = 1'b1;
    run_seq(2, 99);   // R12 full restart
    check_tail();

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      nvec++;
      nfail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule